// File: doc/BRIEF.md
# Dual-Width Accumulator ALU with Flag Generation

A purely combinational arithmetic/logic unit for a 16-bit accumulator machine whose data width can be switched between 8 and 16 bits while it runs. It takes a first operand (accumulator or index register), a second operand (memory or immediate value), a carry-in, a 4-bit operation code and a width select. It returns the result, candidate values for the negative (N), overflow (V), zero (Z) and carry (C) flags, and a 4-bit update mask that tells the status register which of those candidates to write.

When the narrow width is selected, the arithmetic happens on the low byte only. All flags come from bit 7 and the low byte, and the upper result byte passes the first operand's upper byte through unchanged. Candidate flag values whose mask bit is clear carry no meaning. Decimal arithmetic, operand fetch and register storage sit outside this unit.

Top module: `dw_alu`

## Requirements
- R1: Add (code 0): result = A + B + cin over the active width. C = carry out of the top active bit. V = signed overflow. N = result top bit. Z = result is zero.
- R2: Subtract (code 1): result = A - B - (1 - cin). C = 1 when no borrow occurred. V = signed overflow of the difference. N and Z follow the difference.
- R3: Compare (code 10): the result equals A. Z = (A == B). C = (A >= B unsigned). N = top bit of A - B. V is not updated.
- R4: AND (code 2), OR (code 3) and XOR (code 4) of A and B update only N (result top bit) and Z (result zero).
- R5: Increment (code 8) and decrement (code 9) of A update only N and Z of the result.
- R6: Shift left (code 11) moves A's top bit into C and puts 0 in bit 0. Shift right (code 12) moves A bit 0 into C and puts 0 in the top bit, so N is 0. Both also update Z.
- R7: Rotate left (code 13) moves cin into bit 0 and A's top bit into C. Rotate right (code 14) moves cin into the top bit and A bit 0 into C. Both update N and Z.
- R8: Memory bit test (code 5): N = top bit of B, V = the bit below it, Z = ((A & B) == 0), and the result equals A. Immediate bit test (code 6) updates only Z.
- R9: Test-and-set (code 7) gives B | A. Test-and-reset (code 15) gives B & ~A. Both update only Z, which is ((A & B) == 0).
- R10: With wide_i = 0, only bits [7:0] take part in every operation. Result bits [15:8] equal A bits [15:8], and all flags come from bit 7 and the low byte.
- R11: upd_o bit 3 = N, bit 2 = V, bit 1 = Z, bit 0 = C. The mask is NVZC for codes 0 and 1, NZC for codes 10 and 11 to 14, NZ for codes 2 to 4, 8 and 9, NVZ for code 5, and Z alone for codes 6, 7 and 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | First operand (register side) |
| b_i | input | 16 | Second operand (memory/immediate side) |
| cin_i | input | 1 | Carry-in for add, subtract and rotates |
| op_i | input | 4 | Operation code |
| wide_i | input | 1 | 1 = 16-bit, 0 = 8-bit operation |
| res_o | output | 16 | Result |
| n_o | output | 1 | Candidate negative flag |
| v_o | output | 1 | Candidate overflow flag |
| z_o | output | 1 | Candidate zero flag |
| c_o | output | 1 | Candidate carry flag |
| upd_o | output | 4 | Flag update mask {N,V,Z,C} |

## Verification
The unit holds no state, so any fault shows on the outputs in the same evaluation as the stimulus that exposes it. A lane picked for the wrong width shows as a carry or sign taken from bit 15 instead of bit 7, or as a clobbered upper byte. Both appear at once on operands near 0x7F/0x80/0xFF. A wrong mask entry shows as a flag written or left alone for the wrong operation class, and is seen on the first vector of that code. Sweeping every code at both widths and both carry-in values, over corner and pseudo-random operands, reaches each of these paths.

// File: rtl/dw_alu_pkg.sv
package dw_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_AND = 4'd2,
    OP_OR  = 4'd3,
    OP_XOR = 4'd4,
    OP_BTM = 4'd5,
    OP_BTI = 4'd6,
    OP_TSS = 4'd7,
    OP_INC = 4'd8,
    OP_DEC = 4'd9,
    OP_CMP = 4'd10,
    OP_SHL = 4'd11,
    OP_SHR = 4'd12,
    OP_ROL = 4'd13,
    OP_ROR = 4'd14,
    OP_TSR = 4'd15
  } alu_op_e;

  // update mask bit positions
  localparam int unsigned UPD_N = 3;
  localparam int unsigned UPD_V = 2;
  localparam int unsigned UPD_Z = 1;
  localparam int unsigned UPD_C = 0;
endpackage

// File: rtl/dw_alu_lane.sv
module dw_alu_lane
  import dw_alu_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  alu_op_e      op_i,
  output logic [W-1:0] res_o,
  output logic         n_o,
  output logic         v_o,
  output logic         z_o,
  output logic         c_o
);
  localparam int unsigned MSB = W - 1;

  logic [W:0]   sum;
  logic [W-1:0] tst;
  logic         from_res;

  assign tst = a_i & b_i;

  always_comb begin
    sum      = '0;
    res_o    = a_i;
    v_o      = 1'b0;
    c_o      = 1'b0;
    n_o      = 1'b0;
    z_o      = 1'b0;
    from_res = 1'b1;
    unique case (op_i)
      OP_ADD: begin
        sum   = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
        res_o = sum[W-1:0];
        c_o   = sum[W];
        v_o   = (a_i[MSB] == b_i[MSB]) && (sum[MSB] != a_i[MSB]);
      end
      OP_SUB: begin
        sum   = {1'b0, a_i} + {1'b0, ~b_i} + {{W{1'b0}}, cin_i};
        res_o = sum[W-1:0];
        c_o   = sum[W];
        v_o   = (a_i[MSB] != b_i[MSB]) && (sum[MSB] != a_i[MSB]);
      end
      OP_CMP: begin
        sum      = {1'b0, a_i} + {1'b0, ~b_i} + {{W{1'b0}}, 1'b1};
        c_o      = sum[W];
        n_o      = sum[MSB];
        z_o      = ~|sum[W-1:0];
        from_res = 1'b0;
      end
      OP_AND: res_o = a_i & b_i;
      OP_OR:  res_o = a_i | b_i;
      OP_XOR: res_o = a_i ^ b_i;
      OP_INC: res_o = a_i + {{(W-1){1'b0}}, 1'b1};
      OP_DEC: res_o = a_i - {{(W-1){1'b0}}, 1'b1};
      OP_SHL: begin
        res_o = {a_i[W-2:0], 1'b0};
        c_o   = a_i[MSB];
      end
      OP_SHR: begin
        res_o = {1'b0, a_i[W-1:1]};
        c_o   = a_i[0];
      end
      OP_ROL: begin
        res_o = {a_i[W-2:0], cin_i};
        c_o   = a_i[MSB];
      end
      OP_ROR: begin
        res_o = {cin_i, a_i[W-1:1]};
        c_o   = a_i[0];
      end
      OP_BTM: begin
        n_o      = b_i[MSB];
        v_o      = b_i[MSB-1];
        z_o      = ~|tst;
        from_res = 1'b0;
      end
      OP_BTI: begin
        z_o      = ~|tst;
        from_res = 1'b0;
      end
      OP_TSS: begin
        res_o    = b_i | a_i;
        z_o      = ~|tst;
        from_res = 1'b0;
      end
      OP_TSR: begin
        res_o    = b_i & ~a_i;
        z_o      = ~|tst;
        from_res = 1'b0;
      end
      default: ;
    endcase
    // result-derived N/Z for all value-producing classes
    if (from_res) begin
      n_o = res_o[MSB];
      z_o = ~|res_o;
    end
  end
endmodule

// File: rtl/dw_alu_mask.sv
module dw_alu_mask
  import dw_alu_pkg::*;
(
  input  alu_op_e    op_i,
  output logic [3:0] upd_o
);
  always_comb begin
    upd_o = 4'b0000;
    unique case (op_i)
      OP_ADD, OP_SUB:                          upd_o = 4'b1111;
      OP_CMP, OP_SHL, OP_SHR, OP_ROL, OP_ROR:  upd_o = 4'b1011;
      OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC:   upd_o = 4'b1010;
      OP_BTM:                                  upd_o = 4'b1110;
      OP_BTI, OP_TSS, OP_TSR:                  upd_o = 4'b0010;
      default: ;
    endcase
  end
endmodule

// File: rtl/dw_alu.sv
module dw_alu
  import dw_alu_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          cin_i,
  input  logic [3:0]    op_i,
  input  logic          wide_i,
  output logic [DW-1:0] res_o,
  output logic          n_o,
  output logic          v_o,
  output logic          z_o,
  output logic          c_o,
  output logic [3:0]    upd_o
);
  localparam int unsigned HW    = DW / 2;
  localparam int unsigned NLANE = 2;

  alu_op_e op;
  assign op = alu_op_e'(op_i);

  logic [DW-1:0] l_res [NLANE];
  logic          l_n   [NLANE];
  logic          l_v   [NLANE];
  logic          l_z   [NLANE];
  logic          l_c   [NLANE];

  // lane 0: narrow, lane 1: full width
  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    localparam int unsigned LW = (g == 0) ? HW : DW;
    logic [LW-1:0] r;
    dw_alu_lane #(.W(LW)) u_lane (
      .a_i   (a_i[LW-1:0]),
      .b_i   (b_i[LW-1:0]),
      .cin_i (cin_i),
      .op_i  (op),
      .res_o (r),
      .n_o   (l_n[g]),
      .v_o   (l_v[g]),
      .z_o   (l_z[g]),
      .c_o   (l_c[g])
    );
    if (LW < DW) begin : g_pad
      assign l_res[g] = {a_i[DW-1:LW], r};
    end else begin : g_full
      assign l_res[g] = r;
    end
  end

  dw_alu_mask u_mask (
    .op_i  (op),
    .upd_o (upd_o)
  );

  always_comb begin
    if (wide_i) begin
      res_o = l_res[1];
      n_o   = l_n[1];
      v_o   = l_v[1];
      z_o   = l_z[1];
      c_o   = l_c[1];
    end else begin
      res_o = l_res[0];
      n_o   = l_n[0];
      v_o   = l_v[0];
      z_o   = l_z[0];
      c_o   = l_c[0];
    end
  end

  // checks across lane and mask logic
  logic [DW-1:0] wmask;
  assign wmask = wide_i ? {DW{1'b1}} : {{(DW-HW){1'b0}}, {HW{1'b1}}};

  always_comb begin
    AST_V_ONLY_ARITH_BIT: assert (!upd_o[UPD_V] || op == OP_ADD || op == OP_SUB || op == OP_BTM); // R11
    if (op == OP_CMP)
      AST_EQ_IMPLIES_GE: assert (!z_o || c_o); // R3
    if (op == OP_SHR)
      AST_SHR_NOT_NEG: assert (!n_o); // R6
    if (op == OP_TSS)
      AST_SET_BITS_HELD: assert (((res_o & a_i) & wmask) == (a_i & wmask)); // R9
    if (op == OP_TSR)
      AST_RESET_BITS_GONE: assert (((res_o & a_i) & wmask) == '0); // R9
    if (op == OP_INC)
      AST_INC_WRAP_ZERO: assert (z_o == ((a_i & wmask) == wmask)); // R5
    if (!wide_i)
      AST_UPPER_PASS: assert (res_o[DW-1:HW] == a_i[DW-1:HW]); // R10
  end
endmodule

// File: tb/tb_dw_alu.sv
module tb_dw_alu;
  localparam int unsigned DW = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [DW-1:0] a, b, res;
  logic          cin, wide, n, v, z, c;
  logic [3:0]    op, upd;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;

  dw_alu #(.DW(DW)) dut (
    .a_i(a), .b_i(b), .cin_i(cin), .op_i(op), .wide_i(wide),
    .res_o(res), .n_o(n), .v_o(v), .z_o(z), .c_o(c), .upd_o(upd)
  );

  function automatic string req_of(input int o);
    case (o)
      0: return "R1";
      1: return "R2";
      10: return "R3";
      2, 3, 4: return "R4";
      8, 9: return "R5";
      11, 12: return "R6";
      13, 14: return "R7";
      5, 6: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s op=%0d wide=%0b cin=%0b a=%h b=%h: actual=%h expected=%h",
               req, what, op, wide, cin, a, b, act, exp);
    end
  endtask

  task automatic run_vec(input int o, input bit w, input bit ci, input int av, input int bv);
    int wd, m, msb, aa, bb, r, s, e_n, e_v, e_z, e_c, e_upd, full;
    string rq;
    op = 4'(o); wide = w; cin = ci; a = DW'(av); b = DW'(bv);
    @(negedge clk);
    wd = w ? 16 : 8;
    m = (1 << wd) - 1;
    msb = 1 << (wd - 1);
    aa = av & m; bb = bv & m;
    r = aa; e_n = 0; e_v = 0; e_z = 0; e_c = 0;
    case (o)
      0: begin s = aa + bb + ci; r = s & m; e_c = (s >> wd) & 1;
           e_v = (((~(aa ^ bb)) & (aa ^ r) & msb) != 0) ? 1 : 0; end
      1: begin s = aa + ((~bb) & m) + ci; r = s & m; e_c = (s >> wd) & 1;
           e_v = (((aa ^ bb) & (aa ^ r) & msb) != 0) ? 1 : 0; end
      2: r = aa & bb;
      3: r = aa | bb;
      4: r = aa ^ bb;
      8: r = (aa + 1) & m;
      9: r = (aa - 1) & m;
      11: begin r = (aa << 1) & m; e_c = (aa & msb) != 0 ? 1 : 0; end
      12: begin r = aa >> 1; e_c = aa & 1; end
      13: begin r = ((aa << 1) | ci) & m; e_c = (aa & msb) != 0 ? 1 : 0; end
      14: begin r = (aa >> 1) | (ci ? msb : 0); e_c = aa & 1; end
      7: r = bb | aa;
      15: r = bb & ((~aa) & m);
      default: ;
    endcase
    e_n = (r & msb) != 0 ? 1 : 0;
    e_z = (r == 0) ? 1 : 0;
    if (o == 10) begin
      s = (aa - bb) & m;
      e_n = (s & msb) != 0 ? 1 : 0;
      e_z = (aa == bb) ? 1 : 0;
      e_c = (aa >= bb) ? 1 : 0;
    end
    if (o == 5 || o == 6 || o == 7 || o == 15) e_z = ((aa & bb) == 0) ? 1 : 0;
    if (o == 5) begin
      e_n = (bb & msb) != 0 ? 1 : 0;
      e_v = (bb & (msb >> 1)) != 0 ? 1 : 0;
    end
    case (o)
      0, 1: e_upd = 4'b1111;
      10, 11, 12, 13, 14: e_upd = 4'b1011;
      2, 3, 4, 8, 9: e_upd = 4'b1010;
      5: e_upd = 4'b1110;
      default: e_upd = 4'b0010;
    endcase
    rq = req_of(o);
    full = w ? r : ((av & 16'hFF00) | r);
    chk(rq, "res", int'(res), full);
    chk("R11", "upd", int'(upd), e_upd);
    if (!w) chk("R10", "upper", int'(res[15:8]), (av >> 8) & 8'hFF);
    if (e_upd[3]) chk(rq, "N", int'(n), e_n);
    if (e_upd[2]) chk(rq, "V", int'(v), e_v);
    if (e_upd[1]) chk(rq, "Z", int'(z), e_z);
    if (e_upd[0]) chk(rq, "C", int'(c), e_c);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int corner [8] = '{'h0000, 'h0001, 'h007F, 'h0080, 'h00FF, 'h7FFF, 'h8000, 'hFFFF};
    logic [15:0] lf;
    a = '0; b = '0; cin = 1'b0; op = 4'd0; wide = 1'b0;
    // idle state: zero inputs, add
    @(negedge clk);
    chk("R1", "idle res", int'(res), 0);
    chk("R1", "idle Z", int'(z), 1);
    lf = 16'hACE1;
    for (int o = 0; o < 16; o++)
      for (int w = 0; w < 2; w++)
        for (int ci = 0; ci < 2; ci++) begin
          for (int i = 0; i < 8; i++)
            for (int j = 0; j < 8; j++)
              run_vec(o, w[0], ci[0], corner[i], corner[j]);
          for (int k = 0; k < 24; k++) begin
            int x;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            x = int'(lf);
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            run_vec(o, w[0], ci[0], x, int'(lf));
          end
        end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule